// File: doc/BRIEF.md
# Atomic Reservation Tracker

This block holds the one reservation a processor core keeps for a lock-free read-modify-write sequence. When the core issues a reserve request with a word address, the block records the 32-byte granule that contains that address and marks the reservation live. When the core later issues a conditional-store request, the block reports on the next cycle whether the store may commit. The outcome depends only on whether a reservation is still live. It does not depend on which address the store targets.

Writes made by other bus masters arrive on a snoop port. Any such write that lands anywhere in the reserved granule cancels the reservation. Every conditional store also cancels it, whether the store succeeds or fails. Both request types must use word-aligned addresses. A misaligned request produces a one-cycle alignment-fault pulse, and the reservation is left exactly as it was. The block never raises a data-storage fault, so write-through regions need no special handling.

Top module: `resv_monitor`

## Requirements
- R1: After reset there is no live reservation and both outputs are low, so a conditional store issued right after reset reports failure.
- R2: An aligned reserve request records the granule tag `req_addr_i[31:5]` and makes the reservation live.
- R3: An aligned conditional store reports success as a one-cycle `sc_success_o` pulse on the cycle after the request if a reservation is live, even when the store address lies in a different granule.
- R4: Every aligned conditional store cancels the reservation, whether it succeeds or fails, so a second store with no new reserve reports failure.
- R5: A snoop write whose `snoop_addr_i[31:5]` equals the stored tag cancels the reservation, at any byte offset 0 to 31. A snoop write to any other granule has no effect on it.
- R6: A request whose address has `req_addr_i[1:0]` nonzero produces an `align_fault_o` pulse on the next cycle, no success pulse, and no change to the reservation's live flag or tag.
- R7: When a snoop hit on the reserved granule and an aligned conditional store occur in the same cycle, the store reports failure.
- R8: When an aligned reserve request and a snoop hit on the old granule occur in the same cycle, the new reservation is live, unless the snoop address also falls in the new granule, in which case no reservation is live.
- R9: A later aligned reserve replaces the stored tag, so snoop writes to the earlier granule no longer cancel it.
- R10: When an aligned reserve and an aligned conditional store occur in the same cycle, the store is judged against the reservation held before that cycle, and afterwards the new reservation is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr_i | input | 32 | Effective address of the reserve or conditional-store request |
| reserve_i | input | 1 | Reserve request strobe |
| cond_store_i | input | 1 | Conditional-store request strobe |
| snoop_we_i | input | 1 | A write by another master is seen this cycle |
| snoop_addr_i | input | 32 | Byte address of the snooped write |
| sc_success_o | output | 1 | Registered pulse: the conditional store may commit |
| align_fault_o | output | 1 | Registered pulse: the request address was not word aligned |

## Verification
The bench targets the same-cycle collisions. These are a snoop hit together with a conditional store, a reserve together with a snoop on the old or on the new granule, and a reserve together with a store. A design that ordered these events wrongly would report a stale success or drop a fresh reservation. It also probes the edges of the granule, offset 0x1C inside and 0x20 just outside. A comparator with the wrong width would then cancel on a neighbour's write or miss a write to the last word. Finally, a misaligned reserve to a different granule is followed by a snoop on the original granule. A design that updated the tag on a faulting request would keep a reservation that should have been cancelled.

// File: rtl/resv_pkg.sv
`timescale 1ns/1ps
package resv_pkg;
    // Default geometry shared by the tracker and its checker
    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_GRAN_BYTES = 32;
    localparam int unsigned DEF_WORD_BYTES = 4;
endpackage

// File: rtl/resv_align_chk.sv
`timescale 1ns/1ps
module resv_align_chk #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned ALIGN_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              aligned
);
    generate
        if (ALIGN_W == 0) begin : g_byte
            assign aligned = 1'b1;
        end else begin : g_word
            assign aligned = ~|addr[ALIGN_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/resv_gran_match.sv
`timescale 1ns/1ps
module resv_gran_match #(
    parameter int unsigned TAG_W = 27
) (
    input  logic [TAG_W-1:0] tag_a,
    input  logic [TAG_W-1:0] tag_b,
    output logic             hit
);
    assign hit = (tag_a == tag_b);
endmodule

// File: rtl/resv_monitor.sv
`timescale 1ns/1ps
module resv_monitor
    import resv_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned GRAN_BYTES = DEF_GRAN_BYTES,
    parameter int unsigned WORD_BYTES = DEF_WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              reserve_i,
    input  logic              cond_store_i,
    input  logic              snoop_we_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    output logic              sc_success_o,
    output logic              align_fault_o
);
    localparam int unsigned OFF_W   = $clog2(GRAN_BYTES);
    localparam int unsigned ALIGN_W = $clog2(WORD_BYTES);
    localparam int unsigned TAG_W   = ADDR_W - OFF_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic             success;
        logic             fault;
    } state_t;

    state_t state_d, state_q;

    logic [TAG_W-1:0] req_tag, snoop_tag;
    logic             req_aligned;
    logic             snoop_eq_old, snoop_eq_new;
    logic             hit_old, hit_new;

    assign req_tag   = req_addr_i[ADDR_W-1:OFF_W];
    assign snoop_tag = snoop_addr_i[ADDR_W-1:OFF_W];

    // Offset bits inside a granule play no part in tag comparison
    logic unused_low;
    assign unused_low = ^{snoop_addr_i[OFF_W-1:0], req_addr_i[OFF_W-1:0]};

    resv_align_chk #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W)) u_align (
        .addr    (req_addr_i),
        .aligned (req_aligned)
    );

    resv_gran_match #(.TAG_W(TAG_W)) u_match_old (
        .tag_a (snoop_tag),
        .tag_b (state_q.tag),
        .hit   (snoop_eq_old)
    );

    resv_gran_match #(.TAG_W(TAG_W)) u_match_new (
        .tag_a (snoop_tag),
        .tag_b (req_tag),
        .hit   (snoop_eq_new)
    );

    assign hit_old = snoop_we_i & state_q.valid & snoop_eq_old;
    assign hit_new = snoop_we_i & snoop_eq_new;

    always_comb begin
        state_d         = state_q;
        state_d.success = 1'b0;
        state_d.fault   = (reserve_i | cond_store_i) & ~req_aligned;

        // Remote write to the held granule cancels it first
        if (hit_old) begin
            state_d.valid = 1'b0;
        end

        // Store is judged against the reservation held before this cycle
        if (cond_store_i && req_aligned) begin
            state_d.success = state_q.valid & ~hit_old;
            state_d.valid   = 1'b0;
        end

        // A new reservation is taken after the store consumed the old one
        if (reserve_i && req_aligned) begin
            state_d.tag   = req_tag;
            state_d.valid = ~hit_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sc_success_o  = state_q.success;
    assign align_fault_o = state_q.fault;
endmodule

// File: rtl/resv_monitor_sva.sv
`timescale 1ns/1ps
module resv_monitor_sva #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 5,
    parameter int unsigned ALIGN_W = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       req_addr_i,
    input logic                    reserve_i,
    input logic                    cond_store_i,
    input logic                    snoop_we_i,
    input logic [ADDR_W-1:0]       snoop_addr_i,
    input logic                    sc_success_o,
    input logic                    align_fault_o,
    input logic                    resv_valid,
    input logic [ADDR_W-OFF_W-1:0] resv_tag
);
    logic aligned_c;
    logic snoop_hit_c;
    assign aligned_c   = (req_addr_i[ALIGN_W-1:0] == '0);
    assign snoop_hit_c = snoop_we_i && resv_valid &&
                         (snoop_addr_i[ADDR_W-1:OFF_W] == resv_tag);

    // R3: success only follows a store made while a reservation was live
    p_success_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sc_success_o |-> ($past(cond_store_i) && $past(resv_valid)));

    // R4: an aligned store without a reserve leaves nothing live
    p_store_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_store_i && aligned_c && !reserve_i) |=> !resv_valid);

    // R5: a snoop hit without a reserve cancels the reservation
    p_snoop_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit_c && !reserve_i) |=> !resv_valid);

    // R6: a faulting request leaves the reservation untouched
    p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((reserve_i || cond_store_i) && !aligned_c && !snoop_we_i) |=>
        (resv_valid == $past(resv_valid) && resv_tag == $past(resv_tag)));

    // R6: fault and success never coincide
    p_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_success_o && align_fault_o));

    // R7: a store colliding with a snoop hit fails
    p_collide_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_store_i && aligned_c && snoop_hit_c) |=> !sc_success_o);
endmodule

bind resv_monitor resv_monitor_sva #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .ALIGN_W (ALIGN_W)
) u_resv_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_addr_i    (req_addr_i),
    .reserve_i     (reserve_i),
    .cond_store_i  (cond_store_i),
    .snoop_we_i    (snoop_we_i),
    .snoop_addr_i  (snoop_addr_i),
    .sc_success_o  (sc_success_o),
    .align_fault_o (align_fault_o),
    .resv_valid    (state_q.valid),
    .resv_tag      (state_q.tag)
);

// File: tb/tb_resv_monitor.sv
`timescale 1ns/1ps
module tb_resv_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic        reserve_i = 1'b0;
    logic        cond_store_i = 1'b0;
    logic        snoop_we_i = 1'b0;
    logic [31:0] snoop_addr_i = '0;
    logic        sc_success_o;
    logic        align_fault_o;

    always #10 clk = ~clk;  // 50 MHz

    resv_monitor dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_addr_i    (req_addr_i),
        .reserve_i     (reserve_i),
        .cond_store_i  (cond_store_i),
        .snoop_we_i    (snoop_we_i),
        .snoop_addr_i  (snoop_addr_i),
        .sc_success_o  (sc_success_o),
        .align_fault_o (align_fault_o)
    );

    typedef struct {
        bit    succ;
        bit    flt;
        string rq;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    bit          m_valid = 1'b0;
    logic [26:0] m_tag = '0;

    // Driver: applies one cycle of stimulus, pushes its expected outcome
    task automatic drive(input bit r, input bit c, input logic [31:0] a,
                         input bit s, input logic [31:0] sa, input string rq);
        bit   mis, hit_old, hit_new, nv;
        exp_t e;
        @(negedge clk);
        reserve_i    = r;
        cond_store_i = c;
        req_addr_i   = a;
        snoop_we_i   = s;
        snoop_addr_i = sa;
        mis     = (a[1:0] != 2'b00);
        hit_old = s && m_valid && (sa[31:5] == m_tag);
        hit_new = s && (sa[31:5] == a[31:5]);
        nv      = m_valid;
        e.succ  = 1'b0;
        e.flt   = (r || c) && mis;
        e.rq    = rq;
        if (hit_old) nv = 1'b0;
        if (c && !mis) begin
            e.succ = m_valid && !hit_old;
            nv     = 1'b0;
        end
        if (r && !mis) begin
            m_tag = a[31:5];
            nv    = !hit_new;
        end
        m_valid = nv;
        sb.push_back(e);
    endtask

    task automatic idle(input string rq);
        drive(0, 0, 32'h0, 0, 32'h0, rq);
    endtask

    // Monitor: compares each registered result after the edge it settles on
    always begin
        @(posedge clk);
        #5;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (sc_success_o !== e.succ || align_fault_o !== e.flt) begin
                errors++;
                $display("FAIL %s: success=%b fault=%b expected success=%b fault=%b",
                         e.rq, sc_success_o, align_fault_o, e.succ, e.flt);
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs low out of reset
        checks++;
        if (sc_success_o !== 1'b0 || align_fault_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: success=%b fault=%b expected 0 0", sc_success_o, align_fault_o);
        end
        drive(0, 1, 32'h0000_0100, 0, 0, "R1");           // store after reset fails

        // R2/R3: reserve then store to another granule succeeds
        drive(1, 0, 32'h0000_1000, 0, 0, "R2");
        drive(0, 1, 32'h0000_2000, 0, 0, "R3");
        drive(0, 1, 32'h0000_2000, 0, 0, "R4");           // consumed
        drive(1, 0, 32'h0000_1000, 0, 0, "R2");
        idle("R3");
        drive(0, 1, 32'h0000_1000, 0, 0, "R3");           // succeeds after idle gap
        idle("R3");                                       // pulse lasts one cycle

        // R5: granule edges
        drive(1, 0, 32'h0000_1000, 0, 0, "R5");
        drive(0, 0, 32'h0, 1, 32'h0000_101C, "R5");       // last word inside
        drive(0, 1, 32'h0000_1000, 0, 0, "R5");
        drive(1, 0, 32'h0000_1000, 0, 0, "R5");
        drive(0, 0, 32'h0, 1, 32'h0000_1020, "R5");       // just outside
        drive(0, 0, 32'h0, 1, 32'h0000_0FFF, "R5");       // just below
        drive(0, 1, 32'h0000_1000, 0, 0, "R5");

        // R6: misaligned requests
        drive(1, 0, 32'h0000_1000, 0, 0, "R6");
        drive(1, 0, 32'h0000_2002, 0, 0, "R6");           // fault, tag kept
        drive(0, 0, 32'h0, 1, 32'h0000_1008, "R6");       // hits original granule
        drive(0, 1, 32'h0000_1000, 0, 0, "R6");           // so store fails
        drive(1, 0, 32'h0000_3000, 0, 0, "R6");
        drive(0, 1, 32'h0000_3001, 0, 0, "R6");           // fault, no success
        drive(0, 1, 32'h0000_3000, 0, 0, "R6");           // still live: succeeds

        // R7: store and snoop hit together
        drive(1, 0, 32'h0000_4000, 0, 0, "R7");
        drive(0, 1, 32'h0000_4000, 1, 32'h0000_4010, "R7");
        drive(0, 1, 32'h0000_4000, 0, 0, "R7");

        // R8: reserve with snoop on old granule, then on new granule
        drive(1, 0, 32'h0000_1000, 0, 0, "R8");
        drive(1, 0, 32'h0000_3000, 1, 32'h0000_1004, "R8");
        drive(0, 1, 32'h0000_3000, 0, 0, "R8");           // new one live
        drive(1, 0, 32'h0000_1000, 0, 0, "R8");
        drive(1, 0, 32'h0000_3000, 1, 32'h0000_3010, "R8");
        drive(0, 1, 32'h0000_3000, 0, 0, "R8");           // cancelled

        // R9: replaced tag
        drive(1, 0, 32'h0000_1000, 0, 0, "R9");
        drive(1, 0, 32'h0000_4000, 0, 0, "R9");
        drive(0, 0, 32'h0, 1, 32'h0000_1000, "R9");
        drive(0, 1, 32'h0000_4000, 0, 0, "R9");

        // R10: reserve and store in one cycle
        drive(1, 0, 32'h0000_1000, 0, 0, "R10");
        drive(1, 1, 32'h0000_5000, 0, 0, "R10");          // succeeds on old
        drive(0, 0, 32'h0, 1, 32'h0000_1000, "R10");      // old granule: no effect
        drive(0, 1, 32'h0000_5000, 0, 0, "R10");          // new one live
        drive(1, 1, 32'h0000_6000, 0, 0, "R10");          // none before: fails
        drive(0, 1, 32'h0000_6000, 0, 0, "R10");          // new one live

        idle("R4");
        idle("R4");
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule